// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Unit

This unit holds the hazard logic of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). It is purely combinational. It compares the source register numbers of the instruction in the execute stage with the destination register numbers held in the execute/memory and memory/writeback pipeline registers. From that it gives each of the two ALU operands its own bypass select. For a store in the memory stage, it compares the store's data register with a load sitting in writeback. When they match, the store-data select tells the datapath to route the loaded word straight to the memory write port.

The unit also looks at the instruction in decode and the instruction in execute. When a load in execute writes a register that the decode-stage instruction needs as an ALU input, no bypass can deliver the value in time. The unit then raises a stall, which holds the PC and the fetch/decode register, and a bubble, which loads a no-op control word into the decode/execute register, both for one cycle. A value produced three slots ahead is not bypassed, because the register file writes early in the cycle and reads late. The operand muxes, the register file and the branch logic lie outside this block.

Top module: `hz_unit`

## Requirements
- R1: An ALU operand select (`fwd_a` for source 1, `fwd_b` for source 2) reads 2'b10 when the execute-stage source register equals `mem_rd` and `mem_wen` is high.
- R2: An ALU operand select reads 2'b01 when its source register equals `wb_rd` with `wb_wen` high and no execute/memory match exists for that operand.
- R3: When both pipeline registers hold a matching producer for an operand, the select reads 2'b10, so the younger producer wins.
- R4: The two operand selects are decided independently. Both may read 2'b10, both 2'b01, or one of each in the same cycle.
- R5: Register number 0 never produces a bypass (select 2'b00), never sets `fwd_std`, and never causes a stall.
- R6: A producer whose write enable is low never produces a bypass match.
- R7: With no matching producer in either pipeline register, a select reads 2'b00 (register file value). This includes a producer three slots ahead that has already left writeback.
- R8: `fwd_std` is 1 exactly when `mem_is_store` is high, `mem_rs2` is nonzero and equals `wb_rd`, and `wb_is_load` and `wb_wen` are both high.
- R9: `stall` and `bubble` are 1 when `ex_is_load` and `ex_wen` are high, `ex_rd` is nonzero, and either `id_use_rs1` is high with `id_rs1 == ex_rd`, or `id_use_rs2` is high with `id_rs2 == ex_rd` and the decode instruction is not a store.
- R10: A store in decode whose only dependence on the load in execute is its data register (`id_rs2`) causes no stall. A dependence through its address register (`id_rs1`) does stall.
- R11: A non-load producer in execute never causes a stall, and `bubble` always equals `stall`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_rs1 | input | 5 | Source register 1 of the instruction in execute |
| ex_rs2 | input | 5 | Source register 2 of the instruction in execute |
| mem_rd | input | 5 | Destination register held in execute/memory |
| mem_wen | input | 1 | Register write enable held in execute/memory |
| wb_rd | input | 5 | Destination register held in memory/writeback |
| wb_wen | input | 1 | Register write enable held in memory/writeback |
| wb_is_load | input | 1 | Memory/writeback holds a load |
| mem_is_store | input | 1 | Memory stage holds a store |
| mem_rs2 | input | 5 | Store data register of the store in memory |
| id_rs1 | input | 5 | Source register 1 of the instruction in decode |
| id_rs2 | input | 5 | Source register 2 of the instruction in decode |
| id_use_rs1 | input | 1 | Decode instruction reads source 1 |
| id_use_rs2 | input | 1 | Decode instruction reads source 2 |
| id_is_store | input | 1 | Decode instruction is a store |
| ex_rd | input | 5 | Destination register of the instruction in execute |
| ex_wen | input | 1 | Register write enable of the instruction in execute |
| ex_is_load | input | 1 | Execute stage holds a load |
| fwd_a | output | 2 | ALU operand 1 source: 00 register file, 01 writeback, 10 memory |
| fwd_b | output | 2 | ALU operand 2 source, same encoding |
| fwd_std | output | 1 | Store write data taken from the load result in writeback |
| stall | output | 1 | Hold PC and fetch/decode register |
| bubble | output | 1 | Insert no-op control word into decode/execute |

## Verification
The operand selects are driven with a single producer in each pipeline register, with both producers naming the same register, and with the two operands split across the two producers. These cases separate a missing priority from a missing path or a crossed operand. Register 0 and deasserted write enables are offered as false producers, to show that a match needs both a valid register and a write. Load-use patterns cover dependences through source 1, through source 2, through an unused source, and through a store's data register. Together they tell the stall condition apart from a plain register compare, and the store-data bypass from the ALU bypass.

// File: rtl/hz_pkg.sv
package hz_pkg;
    localparam int REG_W = 5;

    typedef enum logic [1:0] {
        SRC_RF  = 2'b00,
        SRC_WB  = 2'b01,
        SRC_MEM = 2'b10
    } opnd_src_e;

    typedef struct packed {
        logic [1:0] fwd_a;
        logic [1:0] fwd_b;
        logic       fwd_std;
        logic       stall;
        logic       bubble;
    } hz_out_t;
endpackage

// File: rtl/hz_match.sv
module hz_match #(
    parameter int RW = 5
) (
    input  logic [RW-1:0] src,
    input  logic [RW-1:0] dst,
    input  logic          wen,
    output logic          hit
);
    localparam logic [RW-1:0] ZERO_REG = '0;

    always_comb begin
        hit = wen && (dst != ZERO_REG) && (src == dst);
    end
endmodule

// File: rtl/hz_pick.sv
module hz_pick
    import hz_pkg::*;
(
    input  logic       hit_mem,
    input  logic       hit_wb,
    output logic [1:0] sel
);
    opnd_src_e sel_d;

    always_comb begin
        if (hit_mem)     sel_d = SRC_MEM;
        else if (hit_wb) sel_d = SRC_WB;
        else             sel_d = SRC_RF;
        sel = sel_d;
    end

    always_comb begin
        // R3
        pick_prio_chk: assert (!hit_mem || sel == SRC_MEM)
            else $error("younger producer lost priority");
    end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
    parameter int RW = 5
) (
    input  logic [RW-1:0] id_rs1,
    input  logic [RW-1:0] id_rs2,
    input  logic          id_use_rs1,
    input  logic          id_use_rs2,
    input  logic          id_is_store,
    input  logic [RW-1:0] ex_rd,
    input  logic          ex_wen,
    input  logic          ex_is_load,
    output logic          stall
);
    logic hit1, hit2, prod_ok;

    hz_match #(.RW(RW)) u_m1 (.src(id_rs1), .dst(ex_rd), .wen(ex_wen), .hit(hit1));
    hz_match #(.RW(RW)) u_m2 (.src(id_rs2), .dst(ex_rd), .wen(ex_wen), .hit(hit2));

    always_comb begin
        prod_ok = ex_is_load;
        // store data can be bypassed later in MEM, so only the address matters
        stall = prod_ok && ((id_use_rs1 && hit1) ||
                            (id_use_rs2 && !id_is_store && hit2));
    end

    always_comb begin
        // R11
        lu_needs_load_chk: assert (!stall || ex_is_load)
            else $error("stall raised without a load in execute");
        // R5
        lu_zero_chk: assert (!(stall && ex_rd == '0))
            else $error("stall on register zero");
    end
endmodule

// File: rtl/hz_unit.sv
module hz_unit
    import hz_pkg::*;
#(
    parameter int RW = REG_W
) (
    input  logic [RW-1:0] ex_rs1,
    input  logic [RW-1:0] ex_rs2,
    input  logic [RW-1:0] mem_rd,
    input  logic          mem_wen,
    input  logic [RW-1:0] wb_rd,
    input  logic          wb_wen,
    input  logic          wb_is_load,
    input  logic          mem_is_store,
    input  logic [RW-1:0] mem_rs2,
    input  logic [RW-1:0] id_rs1,
    input  logic [RW-1:0] id_rs2,
    input  logic          id_use_rs1,
    input  logic          id_use_rs2,
    input  logic          id_is_store,
    input  logic [RW-1:0] ex_rd,
    input  logic          ex_wen,
    input  logic          ex_is_load,
    output logic [1:0]    fwd_a,
    output logic [1:0]    fwd_b,
    output logic          fwd_std,
    output logic          stall,
    output logic          bubble
);
    localparam int NOPND = 2;

    logic [RW-1:0] opnd_src [NOPND];
    logic [1:0]    opnd_sel [NOPND];
    logic          std_hit, lu_stall;
    hz_out_t       res_d;

    always_comb begin
        opnd_src[0] = ex_rs1;
        opnd_src[1] = ex_rs2;
    end

    for (genvar gi = 0; gi < NOPND; gi++) begin : g_opnd
        logic hit_mem, hit_wb;
        hz_match #(.RW(RW)) u_mm (.src(opnd_src[gi]), .dst(mem_rd), .wen(mem_wen), .hit(hit_mem));
        hz_match #(.RW(RW)) u_mw (.src(opnd_src[gi]), .dst(wb_rd),  .wen(wb_wen),  .hit(hit_wb));
        hz_pick u_pick (.hit_mem(hit_mem), .hit_wb(hit_wb), .sel(opnd_sel[gi]));
    end

    hz_match #(.RW(RW)) u_std (
        .src(mem_rs2), .dst(wb_rd), .wen(wb_wen && wb_is_load), .hit(std_hit)
    );

    hz_load_use #(.RW(RW)) u_lu (
        .id_rs1(id_rs1), .id_rs2(id_rs2),
        .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2),
        .id_is_store(id_is_store),
        .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_is_load(ex_is_load),
        .stall(lu_stall)
    );

    always_comb begin
        res_d         = '0;
        res_d.fwd_a   = opnd_sel[0];
        res_d.fwd_b   = opnd_sel[1];
        res_d.fwd_std = mem_is_store && std_hit;
        res_d.stall   = lu_stall;
        res_d.bubble  = lu_stall;
    end

    always_comb begin
        fwd_a   = res_d.fwd_a;
        fwd_b   = res_d.fwd_b;
        fwd_std = res_d.fwd_std;
        stall   = res_d.stall;
        bubble  = res_d.bubble;
    end

    always_comb begin
        // R5
        fwd_zero_chk: assert (ex_rs1 != '0 || fwd_a == SRC_RF)
            else $error("register zero bypassed");
        // R6
        fwd_wen_chk: assert (mem_wen || wb_wen || (fwd_a == SRC_RF && fwd_b == SRC_RF))
            else $error("bypass without write enable");
        // R8
        std_store_chk: assert (!fwd_std || (mem_is_store && wb_is_load))
            else $error("store data bypass outside store after load");
        // R11
        bubble_pair_chk: assert (bubble == stall)
            else $error("bubble and stall differ");
    end
endmodule

// File: tb/hz_unit_tb.sv
module hz_unit_tb;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [4:0] ex_rs1, ex_rs2, mem_rd, wb_rd, mem_rs2, id_rs1, id_rs2, ex_rd;
    logic mem_wen, wb_wen, wb_is_load, mem_is_store;
    logic id_use_rs1, id_use_rs2, id_is_store, ex_wen, ex_is_load;
    logic [1:0] fwd_a, fwd_b;
    logic fwd_std, stall, bubble;

    int n_run = 0;
    int n_fail = 0;

    hz_unit u_dut (
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .mem_rd(mem_rd), .mem_wen(mem_wen),
        .wb_rd(wb_rd), .wb_wen(wb_wen), .wb_is_load(wb_is_load),
        .mem_is_store(mem_is_store), .mem_rs2(mem_rs2),
        .id_rs1(id_rs1), .id_rs2(id_rs2), .id_use_rs1(id_use_rs1),
        .id_use_rs2(id_use_rs2), .id_is_store(id_is_store),
        .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_is_load(ex_is_load),
        .fwd_a(fwd_a), .fwd_b(fwd_b), .fwd_std(fwd_std),
        .stall(stall), .bubble(bubble)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic clear_in();
        @(negedge clk);
        {ex_rs1, ex_rs2, mem_rd, wb_rd, mem_rs2, id_rs1, id_rs2, ex_rd} = '0;
        {mem_wen, wb_wen, wb_is_load, mem_is_store} = '0;
        {id_use_rs1, id_use_rs2, id_is_store, ex_wen, ex_is_load} = '0;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic t_idle();
        clear_in(); settle();
        chk("R7 idle fwd_a", fwd_a, 0);
        chk("R7 idle fwd_b", fwd_b, 0);
        chk("R8 idle fwd_std", fwd_std, 0);
        chk("R11 idle stall", stall, 0);
    endtask

    task automatic t_exmem();
        clear_in(); ex_rs1 = 3; ex_rs2 = 9; mem_rd = 3; mem_wen = 1; settle();
        chk("R1 fwd_a from mem", fwd_a, 2);
        chk("R1 fwd_b untouched", fwd_b, 0);
    endtask

    task automatic t_memwb();
        clear_in(); ex_rs1 = 8; ex_rs2 = 4; wb_rd = 4; wb_wen = 1; mem_rd = 12; mem_wen = 1; settle();
        chk("R2 fwd_b from wb", fwd_b, 1);
        chk("R2 fwd_a untouched", fwd_a, 0);
    endtask

    task automatic t_priority();
        clear_in(); ex_rs1 = 5; ex_rs2 = 5; mem_rd = 5; wb_rd = 5; mem_wen = 1; wb_wen = 1; settle();
        chk("R3 fwd_a prio", fwd_a, 2);
        chk("R3 fwd_b prio", fwd_b, 2);
    endtask

    task automatic t_both();
        clear_in(); ex_rs1 = 6; ex_rs2 = 7; mem_rd = 6; wb_rd = 7; mem_wen = 1; wb_wen = 1; settle();
        chk("R4 split a", fwd_a, 2);
        chk("R4 split b", fwd_b, 1);
        clear_in(); ex_rs1 = 7; ex_rs2 = 6; mem_rd = 6; wb_rd = 7; mem_wen = 1; wb_wen = 1; settle();
        chk("R4 swapped a", fwd_a, 1);
        chk("R4 swapped b", fwd_b, 2);
        clear_in(); ex_rs1 = 11; ex_rs2 = 11; wb_rd = 11; wb_wen = 1; settle();
        chk("R4 same wb a", fwd_a, 1);
        chk("R4 same wb b", fwd_b, 1);
    endtask

    task automatic t_zero();
        clear_in(); mem_wen = 1; wb_wen = 1; settle();
        chk("R5 zero fwd_a", fwd_a, 0);
        chk("R5 zero fwd_b", fwd_b, 0);
        clear_in(); ex_is_load = 1; ex_wen = 1; id_use_rs1 = 1; id_use_rs2 = 1; settle();
        chk("R5 zero no stall", stall, 0);
        clear_in(); mem_is_store = 1; wb_is_load = 1; wb_wen = 1; settle();
        chk("R5 zero no std", fwd_std, 0);
    endtask

    task automatic t_wen();
        clear_in(); ex_rs1 = 2; ex_rs2 = 2; mem_rd = 2; wb_rd = 2; settle();
        chk("R6 no wen a", fwd_a, 0);
        chk("R6 no wen b", fwd_b, 0);
        clear_in(); ex_rs1 = 2; mem_rd = 2; wb_rd = 2; wb_wen = 1; settle();
        chk("R6 mem off wb on", fwd_a, 1);
    endtask

    task automatic t_dist3();
        clear_in(); ex_rs1 = 14; ex_rs2 = 15; mem_rd = 16; wb_rd = 17; mem_wen = 1; wb_wen = 1; settle();
        chk("R7 dist3 a", fwd_a, 0);
        chk("R7 dist3 b", fwd_b, 0);
    endtask

    task automatic t_store_data();
        clear_in(); mem_is_store = 1; mem_rs2 = 10; wb_rd = 10; wb_wen = 1; wb_is_load = 1; settle();
        chk("R8 load to store", fwd_std, 1);
        wb_is_load = 0; settle();
        chk("R8 non-load producer", fwd_std, 0);
        wb_is_load = 1; mem_is_store = 0; settle();
        chk("R8 not a store", fwd_std, 0);
        mem_is_store = 1; mem_rs2 = 11; settle();
        chk("R8 reg mismatch", fwd_std, 0);
        mem_rs2 = 10; wb_wen = 0; settle();
        chk("R8 no wen", fwd_std, 0);
    endtask

    task automatic t_loaduse();
        clear_in(); ex_is_load = 1; ex_wen = 1; ex_rd = 9; id_rs1 = 9; id_use_rs1 = 1; settle();
        chk("R9 rs1 stall", stall, 1);
        chk("R9 rs1 bubble", bubble, 1);
        id_use_rs1 = 0; settle();
        chk("R9 unused rs1", stall, 0);
        id_rs1 = 1; id_rs2 = 9; id_use_rs2 = 1; settle();
        chk("R9 rs2 stall", stall, 1);
        ex_wen = 0; settle();
        chk("R9 load no wen", stall, 0);
    endtask

    task automatic t_store_after_load();
        clear_in(); ex_is_load = 1; ex_wen = 1; ex_rd = 13; id_is_store = 1;
        id_rs1 = 3; id_rs2 = 13; id_use_rs1 = 1; id_use_rs2 = 1; settle();
        chk("R10 store data only", stall, 0);
        id_rs1 = 13; settle();
        chk("R10 store address", stall, 1);
    endtask

    task automatic t_nonload();
        clear_in(); ex_wen = 1; ex_rd = 9; id_rs1 = 9; id_rs2 = 9; id_use_rs1 = 1; id_use_rs2 = 1; settle();
        chk("R11 alu no stall", stall, 0);
        chk("R11 bubble follows", bubble, 0);
    endtask

    initial begin
        fork
            begin
                t_idle();
                t_exmem();
                t_memwb();
                t_priority();
                t_both();
                t_zero();
                t_wen();
                t_dist3();
                t_store_data();
                t_loaduse();
                t_store_after_load();
                t_nonload();
            end
            begin
                repeat (5000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule